// File: doc/BRIEF.md
# Receive Character Buffer with Per-Character Error Flags

This block sits between a serial receiver and a host. Each character the receiver delivers comes with three error flags: parity error, framing error and break. The block stores the character and its flags together as one entry of a small first-in first-out store. The host sees the oldest entry through a holding-register output. The flags of that same entry appear in a line-status view. When the host reads the holding register, the next entry moves to the head, and its flags replace the status bits at once.

A data-ready interrupt tells the host when to collect data. With buffering turned off, the store holds a single character and the interrupt is raised for every character. With buffering turned on, the interrupt waits until a selectable fill level is reached. An idle timer covers bytes left below that level. It counts bit-time ticks while data is waiting. When it reaches a limit based on the word length, it raises a timeout flag that also drives the interrupt.

Characters enter over a valid/ready stream. `in_ready` is high whenever there is room for a character. The serial source cannot stall, so it does not have to wait for `in_ready`. A beat presented while `in_ready` is low is discarded, and a sticky overrun flag is set. A write and a read in the same cycle of a full store still drop the write. `fifo_en` is meant to change only together with a `fifo_clr` pulse.

Top module: `rx_err_fifo`

## Requirements
- R1: The store keeps up to DEPTH (16) entries of 8 data bits plus 3 flag bits each and returns them in arrival order, each byte with the flags that arrived with it.
- R2: `line_stat` bit 0 is high when data is waiting and bit 1 is the overrun flag. Bits 2, 3 and 4 are the parity, framing and break flags of the head entry. Bits 4..2 read zero when the store is empty.
- R3: A one-cycle `rd_strobe` pulse on a non-empty store removes the head. From the next cycle, `hold_data` and `line_stat[4:2]` show the following entry.
- R4: `in_ready` is low when the store holds its capacity. An `in_valid` beat while `in_ready` is low is dropped and sets the overrun flag. The flag stays set until a `lsr_rd` pulse clears it; a new overrun in the same cycle wins over the clear.
- R5: `rd_strobe` on an empty store changes no pointer. `hold_data` keeps showing the last byte removed, and the next character written becomes the head.
- R6: With `fifo_en` high, `trig_sel` values 0, 1, 2 and 3 select fill levels 1, 4, 8 and 14. The level condition holds while the entry count is at or above the selected level.
- R7: With `fifo_en` low, the capacity is one entry and the level condition holds whenever an entry is present.
- R8: The idle limit is 4×(5+`word_len`)+12 `bit_tick` pulses, which is 32, 36, 40 or 44. The count restarts on every write and every removal and runs only while the store is non-empty. `rx_tout` is high once the count reaches the limit.
- R9: `rx_irq` equals `rx_ie` AND (level condition OR `rx_tout`).
- R10: A `fifo_clr` pulse empties the store and clears the stored flags, the overrun flag, the idle count and the last-read byte. Afterwards `hold_data` and `line_stat` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_clr | input | 1 | Synchronous clear of the store |
| fifo_en | input | 1 | 1: full-depth buffering, 0: single entry |
| trig_sel | input | 2 | Fill-level select |
| word_len | input | 2 | Word length code (5 + value data bits) |
| rx_ie | input | 1 | Data-ready interrupt enable |
| bit_tick | input | 1 | One pulse per bit time |
| in_valid | input | 1 | Character beat present |
| in_ready | output | 1 | Room for a character |
| in_data | input | 8 | Received byte |
| in_perr | input | 1 | Parity error of the byte |
| in_ferr | input | 1 | Framing error of the byte |
| in_brk | input | 1 | Break seen with the byte |
| rd_strobe | input | 1 | Host read of the holding register |
| lsr_rd | input | 1 | Host read of the line status |
| hold_data | output | 8 | Head byte, or last byte removed when empty |
| line_stat | output | 5 | Ready, overrun and head flags |
| rx_irq | output | 1 | Data-ready interrupt |
| rx_tout | output | 1 | Idle timeout reached |

## Verification
On every cycle, the assertions check these invariants:
- the entry count never exceeds the depth and moves by at most one;
- a dropped beat leaves the overrun flag set;
- an empty read leaves `hold_data` stable;
- the flags read zero when the store is empty;
- the timeout only shows with data waiting;
- the interrupt stays low while disabled;
- a clear empties the store.

Only the bench's scenarios can show the rest. That covers byte and flag ordering across a full fill and drain, the exact fill levels for every select code, and the exact tick count of the idle limit for each word length.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int DW = 8;
  localparam int TAGW = 3;

  typedef struct packed {
    logic           brk;
    logic           ferr;
    logic           perr;
    logic [DW-1:0]  data;
  } rxf_entry_t;

  localparam int EW = $bits(rxf_entry_t);

  function automatic int unsigned fill_level(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'd0:    fill_level = 1;
      2'd1:    fill_level = depth / 4;
      2'd2:    fill_level = depth / 2;
      default: fill_level = depth - 2;
    endcase
  endfunction

  function automatic int unsigned idle_limit(input logic [1:0] wl);
    idle_limit = 4 * (5 + int'(wl)) + 12;
  endfunction
endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  rxf_entry_t       wentry,
  input  logic             pop,
  output rxf_entry_t       head,
  output logic [CW-1:0]    fill
);
  rxf_entry_t    mem [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    nxt = (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (clr) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push) begin
        mem[wp] <= wentry;
        wp      <= nxt(wp);
      end
      if (pop) rp <= nxt(rp);
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  assign head = mem[rp];
endmodule

// File: rtl/rxf_idle_timer.sv
module rxf_idle_timer
  import rxf_pkg::*;
#(
  localparam int LIMW = $clog2(4 * DW + 13)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            active,
  input  logic            tick,
  input  logic [1:0]      wl,
  output logic            expired
);
  logic [LIMW-1:0] cnt;
  logic [LIMW-1:0] lim;

  assign lim = LIMW'(idle_limit(wl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt <= '0;
    else if (restart || !active)         cnt <= '0;
    else if (tick && (cnt < lim))        cnt <= cnt + 1'b1;
  end

  assign expired = active && (cnt >= lim);
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
  import rxf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_clr,
  input  logic          fifo_en,
  input  logic [1:0]    trig_sel,
  input  logic [1:0]    word_len,
  input  logic          rx_ie,
  input  logic          bit_tick,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_perr,
  input  logic          in_ferr,
  input  logic          in_brk,
  input  logic          rd_strobe,
  input  logic          lsr_rd,
  output logic [DW-1:0] hold_data,
  output logic [4:0]    line_stat,
  output logic          rx_irq,
  output logic          rx_tout
);
  logic [CW-1:0] fill;
  logic [CW-1:0] cap;
  logic [CW-1:0] level;
  rxf_entry_t    wentry, head;
  logic          push, pop, empty, drop;
  logic          ovr;
  logic [DW-1:0] last_data;
  logic          level_hit;

  assign cap      = fifo_en ? CW'(DEPTH) : CW'(1);
  assign level    = fifo_en ? CW'(fill_level(trig_sel, DEPTH)) : CW'(1);
  assign empty    = (fill == '0);
  assign in_ready = (fill < cap);
  assign push     = in_valid && in_ready && !fifo_clr;
  assign drop     = in_valid && !in_ready && !fifo_clr;
  assign pop      = rd_strobe && !empty && !fifo_clr;
  assign wentry   = '{brk: in_brk, ferr: in_ferr, perr: in_perr, data: in_data};

  rxf_store #(.DEPTH(DEPTH)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (fifo_clr),
    .push   (push),
    .wentry (wentry),
    .pop    (pop),
    .head   (head),
    .fill   (fill)
  );

  rxf_idle_timer u_idle (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (push || pop || fifo_clr),
    .active  (!empty),
    .tick    (bit_tick),
    .wl      (word_len),
    .expired (rx_tout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr       <= 1'b0;
      last_data <= '0;
    end else if (fifo_clr) begin
      ovr       <= 1'b0;
      last_data <= '0;
    end else begin
      if (drop)        ovr <= 1'b1;
      else if (lsr_rd) ovr <= 1'b0;
      if (pop) last_data <= head.data;
    end
  end

  assign level_hit = (fill >= level);
  assign hold_data = empty ? last_data : head.data;
  assign line_stat = empty ? {3'b000, ovr, 1'b0}
                           : {head.brk, head.ferr, head.perr, ovr, 1'b1};
  assign rx_irq    = rx_ie && (level_hit || rx_tout);
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_clr,
  input logic          fifo_en,
  input logic          rx_ie,
  input logic          in_valid,
  input logic          in_ready,
  input logic          rd_strobe,
  input logic [7:0]    hold_data,
  input logic [4:0]    line_stat,
  input logic          rx_irq,
  input logic          rx_tout,
  input logic [CW-1:0] fill
);
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

  p_fill_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_clr |=> (fill <= $past(fill) + 1'b1) && (fill + 1'b1 >= $past(fill)));

  p_tags_zero_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !line_stat[0] |-> (line_stat[4:2] == 3'b000));

  p_drop_sets_ovr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !fifo_clr) |=> line_stat[1]);

  p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !line_stat[0] && !in_valid && !fifo_clr) |=> $stable(hold_data));

  p_single_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && line_stat[0]) |-> !in_ready);

  p_tout_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_tout |-> line_stat[0]);

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ie |-> !rx_irq);

  p_clr_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (!line_stat[0] && !line_stat[1]));
endmodule

bind rx_err_fifo rxf_checker #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fifo_clr  (fifo_clr),
  .fifo_en   (fifo_en),
  .rx_ie     (rx_ie),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .rd_strobe (rd_strobe),
  .hold_data (hold_data),
  .line_stat (line_stat),
  .rx_irq    (rx_irq),
  .rx_tout   (rx_tout),
  .fill      (fill)
);

// File: tb/tb_rx_err_fifo.sv
`timescale 1ns/1ps
module tb_rx_err_fifo;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_clr = 1'b0, fifo_en = 1'b1, rx_ie = 1'b1, bit_tick = 1'b0;
  logic [1:0] trig_sel = 2'd0, word_len = 2'd0;
  logic in_valid = 1'b0, in_perr = 1'b0, in_ferr = 1'b0, in_brk = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic rd_strobe = 1'b0, lsr_rd = 1'b0;
  logic in_ready, rx_irq, rx_tout;
  logic [7:0] hold_data;
  logic [4:0] line_stat;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  rx_err_fifo #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .fifo_en(fifo_en),
    .trig_sel(trig_sel), .word_len(word_len), .rx_ie(rx_ie), .bit_tick(bit_tick),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_perr(in_perr), .in_ferr(in_ferr), .in_brk(in_brk),
    .rd_strobe(rd_strobe), .lsr_rd(lsr_rd), .hold_data(hold_data),
    .line_stat(line_stat), .rx_irq(rx_irq), .rx_tout(rx_tout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] t);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; {in_brk, in_ferr, in_perr} = t;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
  endtask

  task automatic lsr();
    @(negedge clk); lsr_rd = 1'b1;
    @(negedge clk); lsr_rd = 1'b0;
  endtask

  task automatic clear();
    @(negedge clk); fifo_clr = 1'b1;
    @(negedge clk); fifo_clr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_tick = 1'b1;
      @(negedge clk); bit_tick = 1'b0;
    end
  endtask

  function automatic int lvl(input int s);
    case (s)
      0: lvl = 1;
      1: lvl = 4;
      2: lvl = 8;
      default: lvl = 14;
    endcase
  endfunction

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(line_stat == 5'd0, "R2 reset status", line_stat, 0);
    chk(in_ready == 1'b1, "R4 reset ready", in_ready, 1);
    chk(hold_data == 8'd0, "R10 reset data", hold_data, 0);

    for (int s = 0; s < 4; s++) begin
      clear();
      fifo_en = 1'b1; trig_sel = 2'(s); rx_ie = 1'b1;
      for (int k = 1; k <= DEPTH; k++) begin
        push(8'((s * 16 + k) * 5), 3'((k + s) % 8));
        chk(rx_irq == (k >= lvl(s)), "R6 fill level irq", rx_irq, int'(k >= lvl(s)));
      end
      chk(in_ready == 1'b0, "R4 full not ready", in_ready, 0);
      push(8'hEE, 3'b111);
      chk(line_stat[1] == 1'b1, "R4 overrun set", line_stat[1], 1);
      lsr();
      chk(line_stat[1] == 1'b0, "R4 overrun cleared", line_stat[1], 0);
      for (int k = 1; k <= DEPTH; k++) begin
        chk(hold_data == 8'((s * 16 + k) * 5), "R1 order data", hold_data, (s * 16 + k) * 5 % 256);
        chk(line_stat[4:2] == 3'((k + s) % 8), "R2 R3 head flags", line_stat[4:2], (k + s) % 8);
        rd();
      end
      chk(line_stat[0] == 1'b0, "R1 dropped beat absent", line_stat[0], 0);
      chk(hold_data == 8'((s * 16 + DEPTH) * 5), "R5 last data", hold_data, (s * 16 + DEPTH) * 5 % 256);
      rd();
      chk(hold_data == 8'((s * 16 + DEPTH) * 5), "R5 empty read keeps", hold_data, (s * 16 + DEPTH) * 5 % 256);
      push(8'h5A, 3'b010);
      chk(hold_data == 8'h5A && line_stat == 5'b01001, "R5 next write is head",
          {hold_data, line_stat}, {8'h5A, 5'b01001});
    end

    clear(); rx_ie = 1'b0; trig_sel = 2'd1;
    for (int k = 0; k < 6; k++) push(8'(k), 3'b000);
    chk(rx_irq == 1'b0, "R9 disabled irq", rx_irq, 0);
    rx_ie = 1'b1;
    @(negedge clk);
    chk(rx_irq == 1'b1, "R9 enabled irq", rx_irq, 1);

    fifo_en = 1'b0; clear();
    chk(rx_irq == 1'b0, "R7 empty no irq", rx_irq, 0);
    push(8'h31, 3'b100);
    chk(rx_irq == 1'b1 && in_ready == 1'b0, "R7 single slot", {rx_irq, in_ready}, 2);
    push(8'h32, 3'b000);
    chk(line_stat[1] == 1'b1 && hold_data == 8'h31, "R7 second dropped", hold_data, 8'h31);
    chk(line_stat[4:2] == 3'b100, "R2 break bit position", line_stat[4:2], 4);
    fifo_en = 1'b1;

    for (int w = 0; w < 4; w++) begin
      clear(); trig_sel = 2'd3; word_len = 2'(w);
      push(8'hA0, 3'b000);
      ticks(32 + 4 * w - 1);
      chk(rx_tout == 1'b0 && rx_irq == 1'b0, "R8 before limit", rx_tout, 0);
      ticks(1);
      chk(rx_tout == 1'b1, "R8 at limit", rx_tout, 1);
      chk(rx_irq == 1'b1, "R9 timeout irq", rx_irq, 1);
      push(8'hA1, 3'b000);
      chk(rx_tout == 1'b0, "R8 restart on write", rx_tout, 0);
      rd(); rd();
      ticks(50);
      chk(rx_tout == 1'b0, "R8 idle while empty", rx_tout, 0);
    end

    clear(); trig_sel = 2'd0;
    for (int k = 0; k < DEPTH + 1; k++) push(8'hC0 + 8'(k), 3'b111);
    chk(line_stat == 5'b11111, "R2 full status", line_stat, 31);
    clear();
    chk(line_stat == 5'd0 && hold_data == 8'd0 && in_ready, "R10 cleared",
        {line_stat, hold_data}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule